// File: doc/BRIEF.md
# Programmable Periodic Error Injector

This block sits in a 64-bit transmit datapath and corrupts chosen data words at a programmable rate. It is used to exercise a downstream FEC decoder with known error patterns. A reloading down-counter, loaded from a 32-bit period input, sets the spacing between corrupted words. A 4-bit type code picks the damage applied to a chosen word: either one flipped bit or a burst of one to eight adjacent, fully inverted bytes.

A two-state pacer controls the counter. In PACE_IDLE the counter tracks the period input and no word is touched. The transition IDLE_TO_RUN fires on a clock where enable is 1 and the period is non-zero. In PACE_RUN the counter steps down once per word. The transition RUN_TO_IDLE fires when enable drops or the period becomes zero. The transition RUN_STAY keeps the state for every other clock, and IDLE_STAY keeps the idle state while injection is not active. On the word where the count steps from one to zero, the mask generator's pattern is XORed into the data and the counter reloads with the period. Data out is registered, so it follows data in by one clock.

Top module: `err_injector`

## Requirements
- R1: While `inj_en` is 0, `dout` equals the previous cycle's `din` and no word is corrupted.
- R2: With `inj_en` held at 1, a constant non-zero period P and a legal type code, the corrupted words are those at enabled cycles P-1, 2P-1, 3P-1 and so on. The first enabled cycle counts as cycle 0.
- R3: Dropping `inj_en` for one or more cycles, or asserting `rst_n` low, restarts the count. The next corrupted word is then at enabled cycle P-1 after the restart.
- R4: A period of zero disables injection: `dout` is the previous `din` unchanged.
- R5: Type code 0 corrupts a selected word by inverting bit 0 only.
- R6: Type codes n = 1 to 8 invert every bit of bytes 0 to n-1, where byte k is bits 8k+7:8k. Code 8 therefore inverts the whole word.
- R7: Type codes 9 to 15 are reserved and corrupt nothing. The counter keeps running and reloading, so the schedule of later hits is unchanged.
- R8: `dout` is a register with one clock of latency and reads 0 after reset.
- R9: A period of 1 corrupts every enabled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset |
| clk | input | 1 | Transmit clock |
| inj_en | input | 1 | Injection enable, active high |
| err_kind | input | 4 | Error type code |
| err_period | input | 32 | Words per injected error; 0 disables |
| din | input | 64 | Data word in |
| dout | output | 64 | Data word out, one clock later |

## Verification
The bench sweeps every type code against periods 1 to 5, starting from a fresh enable each time. This catches an off-by-one in the count, which would shift every hit by a word. It also catches a wrong burst width or start byte, which would flip the wrong bits, and a missing reserved-code guard, which would corrupt data on codes 9 to 15. A period of 1 checks that the reload does not insert an idle word between hits. A period of 0 with enable held checks that a design which wraps its counter through zero, instead of treating zero as off, would be caught. Separate runs drop enable and reset partway through a count, which exposes a counter that resumes instead of restarting. Another run switches to a reserved code exactly on a hit, which exposes a counter that stalls rather than reloading.

// File: rtl/err_inj_pkg.sv
package err_inj_pkg;
    typedef enum logic {
        PACE_IDLE = 1'b0,
        PACE_RUN  = 1'b1
    } pacer_state_t;
endpackage

// File: rtl/err_pacer.sv
module err_pacer
    import err_inj_pkg::*;
#(
    parameter int PERIOD_W = 32
) (
    input  logic                rst_n,
    input  logic                clk,
    input  logic                en,
    input  logic [PERIOD_W-1:0] period,
    output logic                hit
);
    pacer_state_t        state_q, state_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d, cnt_eff;
    logic                active;

    // Injection is live only with enable set and a non-zero period.
    always_comb begin
        active  = en && (period != '0);
        cnt_eff = (state_q == PACE_RUN) ? cnt_q : period;
        hit     = active && (cnt_eff == PERIOD_W'(1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PACE_IDLE: if (active)  state_d = PACE_RUN;   // IDLE_TO_RUN
            PACE_RUN:  if (!active) state_d = PACE_IDLE;  // RUN_TO_IDLE
            default:   state_d = PACE_IDLE;
        endcase
    end

    always_comb begin
        if (!active || hit) cnt_d = period;
        else                cnt_d = cnt_eff - PERIOD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PACE_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/err_mask_gen.sv
module err_mask_gen #(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8,
    parameter int KIND_W = 4
) (
    input  logic [KIND_W-1:0] kind,
    output logic [DATA_W-1:0] mask
);
    localparam int NBYTES = DATA_W / BYTE_W;

    logic [DATA_W-1:0] burst;
    logic              legal_burst;

    assign legal_burst = (kind != '0) && (int'(kind) <= NBYTES);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign burst[b*BYTE_W +: BYTE_W] =
            (legal_burst && (b < int'(kind))) ? {BYTE_W{1'b1}} : '0;
    end

    always_comb begin
        if (kind == '0) mask = DATA_W'(1);
        else            mask = burst;
    end
endmodule

// File: rtl/err_injector.sv
module err_injector
    import err_inj_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int BYTE_W   = 8,
    parameter int KIND_W   = 4,
    parameter int PERIOD_W = 32
) (
    input  logic                rst_n,
    input  logic                clk,
    input  logic                inj_en,
    input  logic [KIND_W-1:0]   err_kind,
    input  logic [PERIOD_W-1:0] err_period,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout
);
    logic              hit;
    logic [DATA_W-1:0] mask;

    err_pacer #(.PERIOD_W(PERIOD_W)) u_pacer (
        .rst_n  (rst_n),
        .clk    (clk),
        .en     (inj_en),
        .period (err_period),
        .hit    (hit)
    );

    err_mask_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .KIND_W(KIND_W)) u_mask (
        .kind (err_kind),
        .mask (mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= hit ? (din ^ mask) : din;
    end
endmodule

// File: rtl/err_injector_chk.sv
module err_injector_chk #(
    parameter int DATA_W   = 64,
    parameter int KIND_W   = 4,
    parameter int PERIOD_W = 32
) (
    input logic                rst_n,
    input logic                clk,
    input logic                inj_en,
    input logic [KIND_W-1:0]   err_kind,
    input logic [PERIOD_W-1:0] err_period,
    input logic [DATA_W-1:0]   din,
    input logic [DATA_W-1:0]   dout
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_off_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(inj_en)) |-> (dout == $past(din)));

    assert_zero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(err_period) == '0) |-> (dout == $past(din)));

    assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(err_kind) == '0) |-> ((dout ^ $past(din)) == '0 || (dout ^ $past(din)) == DATA_W'(1)));

    assert_burst_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(err_kind) != '0 && int'($past(err_kind)) <= 8) |->
        ($countones(dout ^ $past(din)) == 0 || $countones(dout ^ $past(din)) == 8 * int'($past(err_kind))));

    assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && int'($past(err_kind)) > 8) |-> (dout == $past(din)));
endmodule

bind err_injector err_injector_chk #(.DATA_W(DATA_W), .KIND_W(KIND_W), .PERIOD_W(PERIOD_W)) u_chk (
    .rst_n(rst_n), .clk(clk), .inj_en(inj_en), .err_kind(err_kind),
    .err_period(err_period), .din(din), .dout(dout)
);

// File: tb/err_injector_test.sv
module err_injector_test;
    logic        rst_n = 1'b0;
    logic        clk = 1'b0;
    logic        inj_en = 1'b0;
    logic [3:0]  err_kind = '0;
    logic [31:0] err_period = '0;
    logic [63:0] din = '0;
    logic [63:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    int seq = 0;

    always #10 clk = ~clk;

    err_injector uut (
        .rst_n(rst_n), .clk(clk), .inj_en(inj_en), .err_kind(err_kind),
        .err_period(err_period), .din(din), .dout(dout)
    );

    function automatic logic [63:0] exp_mask(input logic [3:0] k);
        logic [63:0] m = '0;
        if (k == 0) return 64'h1;
        if (k > 8) return '0;
        for (int b = 0; b < 8; b++) if (b < int'(k)) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] pattern(input int s);
        return {32'(s) * 32'h9E3779B9, ~(32'(s) * 32'h85EBCA6B)};
    endfunction

    // Drive one word at the falling edge, let one rising edge pass, compare.
    task automatic step(input logic en, input logic [3:0] k, input logic corrupt, input string req);
        logic [63:0] exp;
        inj_en = en;
        err_kind = k;
        seq++;
        din = pattern(seq);
        exp = corrupt ? (din ^ exp_mask(k)) : din;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (dout !== exp) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected=%h", req, dout, exp);
        end
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: timeout actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        n_chk++;
        if (dout !== 64'h0) begin
            n_bad++;
            $display("FAIL R8: reset dout=%h expected=%h", dout, 64'h0);
        end
        rst_n = 1'b1;

        // Sweep of type codes against small periods (R2, R5, R6, R7, R9, R1)
        for (int k = 0; k < 16; k++) begin
            for (int p = 1; p <= 5; p++) begin
                err_period = 32'(p);
                step(1'b0, 4'(k), 1'b0, "R1");
                for (int c = 0; c < 3*p + 2; c++)
                    step(1'b1, 4'(k), (k <= 8) && ((c + 1) % p == 0),
                         (k > 8) ? "R7" : (p == 1) ? "R9" : (k == 0) ? "R5" : "R6");
            end
        end

        // Zero period with enable held (R4)
        err_period = 32'd0;
        for (int c = 0; c < 20; c++) step(1'b1, 4'd8, 1'b0, "R4");

        // Enable drop restarts the count (R3)
        err_period = 32'd4;
        step(1'b0, 4'd0, 1'b0, "R1");
        step(1'b1, 4'd0, 1'b0, "R3");
        step(1'b1, 4'd0, 1'b0, "R3");
        step(1'b0, 4'd0, 1'b0, "R3");
        for (int c = 0; c < 8; c++) step(1'b1, 4'd0, (c % 4) == 3, "R3");

        // Reset mid-count restarts the count (R3)
        step(1'b1, 4'd2, 1'b0, "R3");
        step(1'b1, 4'd2, 1'b0, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        n_chk++;
        if (dout !== 64'h0) begin
            n_bad++;
            $display("FAIL R8: dout in reset=%h expected=%h", dout, 64'h0);
        end
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) step(1'b1, 4'd2, (c % 4) == 3, "R3");

        // Reserved code on a hit keeps the schedule (R7)
        err_period = 32'd3;
        step(1'b0, 4'd0, 1'b0, "R1");
        step(1'b1, 4'd0, 1'b0, "R7");
        step(1'b1, 4'd0, 1'b0, "R7");
        step(1'b1, 4'd9, 1'b0, "R7");
        step(1'b1, 4'd0, 1'b0, "R7");
        step(1'b1, 4'd0, 1'b0, "R7");
        step(1'b1, 4'd0, 1'b1, "R7");

        // Longer period (R2)
        err_period = 32'd200;
        step(1'b0, 4'd3, 1'b0, "R1");
        for (int c = 0; c < 420; c++) step(1'b1, 4'd3, ((c + 1) % 200) == 0, "R2");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule